// File: doc/BRIEF.md
# I2C Target Address Front End with Three-Level Straps

This block is the address stage of an I2C/SMBus target. It watches already-synchronised samples of SCL and SDA and detects START and STOP conditions. It receives the first byte after each START and decides whether that byte names this target. It never drives SCL. It only asks an external open-drain pad to pull SDA low.

The 7-bit bus address is not fixed. It is decoded from one or two strap pins, and each pin reads as low, high or unconnected. The pad logic presents each pin as a pre-decoded two-bit level code. The block does not follow the pins continuously. It captures the decoded address at the first START after reset, and again whenever the register back end pulses a reacquire request. Between those events the pins have no effect.

On a match the block pulls SDA low for the acknowledge clock pulse. It also gives the back end a one-cycle match strobe and the direction bit of the address byte. On a mismatch it stays silent until the next START.

Top module: `i2c_strap_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START at any point, including partway through an address byte, restarts address reception. A STOP returns the block to idle.
- R2: The first byte after a START is taken most significant bit first: seven address bits, then the direction bit (1 = read, 0 = write). On a match, `addr_match_o` pulses for exactly one cycle at the rising SCL edge of the eighth bit, and `rd_nwr_o` takes the direction bit in that same cycle. `rd_nwr_o` changes at no other time.
- R3: On a match, `sda_pull_o` rises on the SCL fall that ends the eighth pulse. It stays high through the ninth (acknowledge) pulse and falls on the SCL fall that ends it. It only changes while SCL is low.
- R4: On a mismatch, the block raises neither `sda_pull_o` nor `addr_match_o`. It ignores all later bus bits until the next START, even a byte that equals its address.
- R5: Level codes per strap pin are 00 = low, 01 = high, 10 = unconnected, 11 = invalid. In two-pin mode (`two_pin_mode` = 1), the address is 1001 followed by three bits chosen by the pair (upper pin, lower pin): low/low → 000, low/open → 001, low/high → 010, open/low → 011, high/low → 100, high/open → 101, high/high → 110, open/high → 111.
- R6: In one-pin mode (`two_pin_mode` = 0), only the lower pin is used: low → 1001000, open → 1001001, high → 1001010. The upper pin is ignored.
- R7: Any strap combination not listed for the current mode gives 1001000. This includes an invalid code on a used pin and open/open in two-pin mode.
- R8: The strap address is captured on the first START after reset and on every cycle where `reacquire_req` is high. At all other times, changes on the strap pins and on `two_pin_mode` have no effect on which address is acknowledged. Until the first capture, the address is 1001000.
- R9: Correct operation requires each SCL high and low phase to last at least 4 clock cycles, with SDA stable for at least 2 cycles around each SCL edge. This covers fast-mode and high-speed-mode rates at typical system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (wired bus level) |
| strap_hi_i | input | 2 | Level code of the upper strap pin |
| strap_lo_i | input | 2 | Level code of the lower strap pin |
| two_pin_mode | input | 1 | 1 = two strap pins decoded, 0 = lower pin only |
| reacquire_req | input | 1 | Recapture the strap address this cycle |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA |
| addr_match_o | output | 1 | One-cycle strobe on an address match |
| rd_nwr_o | output | 1 | Direction of the last matched address byte |

## Verification
The bound checker watches properties that hold on every cycle:
- the SDA pull-down changes only while SCL is low and holds steady while SCL is high;
- the match strobe is a single cycle;
- the direction flag moves only with a strobe;
- the latched address changes only after a START or a reacquire request.

The bench scenarios are needed for the rest. Only they can show the full strap decode table, including the fallback cases. They also show that strap changes are ignored until a reacquire request, that a repeated START or a STOP partway through an address byte is handled, and that bytes after a mismatch are never acknowledged.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
   typedef enum logic [1:0] {
      LVL_LOW   = 2'b00,
      LVL_HIGH  = 2'b01,
      LVL_OPEN  = 2'b10,
      LVL_BAD   = 2'b11
   } strap_lvl_e;

   typedef enum logic [2:0] {
      TS_IDLE,
      TS_ADDR,
      TS_ACK_WAIT,
      TS_ACK_DRIVE,
      TS_DONE
   } tgt_state_e;

   function automatic logic [2:0] pair_sel(strap_lvl_e up, strap_lvl_e dn);
      logic [2:0] r;
      case ({up, dn})
         {LVL_LOW,  LVL_LOW }: r = 3'd0;
         {LVL_LOW,  LVL_OPEN}: r = 3'd1;
         {LVL_LOW,  LVL_HIGH}: r = 3'd2;
         {LVL_OPEN, LVL_LOW }: r = 3'd3;
         {LVL_HIGH, LVL_LOW }: r = 3'd4;
         {LVL_HIGH, LVL_OPEN}: r = 3'd5;
         {LVL_HIGH, LVL_HIGH}: r = 3'd6;
         {LVL_OPEN, LVL_HIGH}: r = 3'd7;
         default:              r = 3'd0;
      endcase
      return r;
   endfunction

   function automatic logic [2:0] single_sel(strap_lvl_e dn);
      logic [2:0] r;
      case (dn)
         LVL_LOW:  r = 3'd0;
         LVL_OPEN: r = 3'd1;
         LVL_HIGH: r = 3'd2;
         default:  r = 3'd0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/i2cst_bus_cond.sv
module i2cst_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
endmodule

// File: rtl/i2cst_strap_latch.sv
module i2cst_strap_latch
   import i2cst_pkg::*;
#(
   parameter int ADDR_W   = 7,
   parameter int MAX_PINS = 2,
   parameter logic [ADDR_W-4:0] ADDR_BASE = 4'b1001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        strap_hi,
   input  logic [1:0]        strap_lo,
   input  logic              two_pin,
   input  logic              start_det,
   input  logic              reacquire,
   output logic [ADDR_W-1:0] addr_q
);
   generate
      if (ADDR_W < 4) begin : g_bad_width
         $fatal(1, "ADDR_W must leave room for three strap bits");
      end
      if (MAX_PINS != 1 && MAX_PINS != 2) begin : g_bad_pins
         $fatal(1, "MAX_PINS must be 1 or 2");
      end
   endgenerate

   logic [2:0] low_bits;
   logic       pending;
   logic       capture;

   generate
      if (MAX_PINS == 2) begin : g_two
         always_comb begin
            if (two_pin) low_bits = pair_sel(strap_lvl_e'(strap_hi), strap_lvl_e'(strap_lo));
            else         low_bits = single_sel(strap_lvl_e'(strap_lo));
         end
      end else begin : g_one
         logic unused_hi;
         assign unused_hi = &{1'b0, two_pin, strap_hi};
         assign low_bits  = single_sel(strap_lvl_e'(strap_lo));
      end
   endgenerate

   assign capture = (pending & start_det) | reacquire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b1;
         addr_q  <= {ADDR_BASE, 3'd0};
      end else begin
         if (start_det) pending <= 1'b0;
         if (capture)   addr_q  <= {ADDR_BASE, low_bits};
      end
   end
endmodule

// File: rtl/i2cst_addr_fsm.sv
module i2cst_addr_fsm
   import i2cst_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_i,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              sda_pull,
   output logic              addr_match,
   output logic              rd_nwr
);
   localparam int CNT_W = $clog2(ADDR_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W);

   tgt_state_e        state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [ADDR_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= TS_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         sda_pull   <= 1'b0;
         addr_match <= 1'b0;
         rd_nwr     <= 1'b0;
      end else begin
         addr_match <= 1'b0;
         if (start_det) begin
            state    <= TS_ADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            state    <= TS_IDLE;
            sda_pull <= 1'b0;
         end else begin
            case (state)
               TS_ADDR: if (scl_rise) begin
                  if (bit_cnt == LAST_BIT) begin
                     if (shreg == own_addr) begin
                        addr_match <= 1'b1;
                        rd_nwr     <= sda_i;
                        state      <= TS_ACK_WAIT;
                     end else begin
                        state <= TS_IDLE;
                     end
                  end else begin
                     shreg   <= {shreg[ADDR_W-2:0], sda_i};
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               TS_ACK_WAIT: if (scl_fall) begin
                  sda_pull <= 1'b1;
                  state    <= TS_ACK_DRIVE;
               end
               TS_ACK_DRIVE: if (scl_fall) begin
                  sda_pull <= 1'b0;
                  state    <= TS_DONE;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target #(
   parameter int ADDR_W   = 7,
   parameter int MAX_PINS = 2,
   parameter logic [ADDR_W-4:0] ADDR_BASE = 4'b1001
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] strap_hi_i,
   input  logic [1:0] strap_lo_i,
   input  logic       two_pin_mode,
   input  logic       reacquire_req,
   output logic       sda_pull_o,
   output logic       addr_match_o,
   output logic       rd_nwr_o
);
   logic              start_det, stop_det, scl_rise, scl_fall;
   logic [ADDR_W-1:0] own_addr;

   i2cst_bus_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .start_det (start_det),
      .stop_det  (stop_det),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall)
   );

   i2cst_strap_latch #(
      .ADDR_W    (ADDR_W),
      .MAX_PINS  (MAX_PINS),
      .ADDR_BASE (ADDR_BASE)
   ) u_strap (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_hi  (strap_hi_i),
      .strap_lo  (strap_lo_i),
      .two_pin   (two_pin_mode),
      .start_det (start_det),
      .reacquire (reacquire_req),
      .addr_q    (own_addr)
   );

   i2cst_addr_fsm #(
      .ADDR_W (ADDR_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_i      (sda_i),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .own_addr   (own_addr),
      .sda_pull   (sda_pull_o),
      .addr_match (addr_match_o),
      .rd_nwr     (rd_nwr_o)
   );
endmodule

// File: rtl/i2cst_checker.sv
module i2cst_checker #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_pull,
   input logic              addr_match,
   input logic              rd_nwr,
   input logic              start_det,
   input logic              reacquire_req,
   input logic [ADDR_W-1:0] own_addr
);
   assert_pull_edge_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_i);

   assert_pull_hold_scl_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i)) |-> $stable(sda_pull));

   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_match |=> !addr_match);

   assert_dir_with_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_nwr) |-> addr_match);

   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(own_addr) |-> $past(start_det || reacquire_req));
endmodule

bind i2c_strap_target i2cst_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_i         (scl_i),
   .sda_pull      (sda_pull_o),
   .addr_match    (addr_match_o),
   .rd_nwr        (rd_nwr_o),
   .start_det     (start_det),
   .reacquire_req (reacquire_req),
   .own_addr      (own_addr)
);

// File: tb/i2c_strap_target_test.sv
`timescale 1ns/1ps
module i2c_strap_target_test;
   localparam int Q = 4;
   localparam logic [1:0] L = 2'b00, H = 2'b01, F = 2'b10, X = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       sda_line;
   logic [1:0] strap_hi = L, strap_lo = L;
   logic       two_pin = 1'b1;
   logic       reacq = 1'b0;
   logic       sda_pull_o, addr_match_o, rd_nwr_o;

   int total = 0;
   int bad = 0;
   bit exp_q[$];

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull_o;

   i2c_strap_target uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_m),
      .sda_i         (sda_line),
      .strap_hi_i    (strap_hi),
      .strap_lo_i    (strap_lo),
      .two_pin_mode  (two_pin),
      .reacquire_req (reacq),
      .sda_pull_o    (sda_pull_o),
      .addr_match_o  (addr_match_o),
      .rd_nwr_o      (rd_nwr_o)
   );

   task automatic chk(bit ok, string req, string what, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic logic [6:0] exp_addr(bit two, logic [1:0] hi, logic [1:0] lo);
      logic [2:0] s;
      if (two) begin
         case ({hi, lo})
            {L, F}: s = 3'd1;
            {L, H}: s = 3'd2;
            {F, L}: s = 3'd3;
            {H, L}: s = 3'd4;
            {H, F}: s = 3'd5;
            {H, H}: s = 3'd6;
            {F, H}: s = 3'd7;
            default: s = 3'd0;
         endcase
      end else begin
         case (lo)
            F: s = 3'd1;
            H: s = 3'd2;
            default: s = 3'd0;
         endcase
      end
      return {4'b1001, s};
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bit(logic b);
      sda_m = b;    tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(logic [7:0] b, bit expack, string req);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; tick(Q);
      chk(sda_pull_o == expack, "R3", "pull before ack pulse", sda_pull_o, expack);
      scl_m = 1'b1; tick(Q);
      chk(!sda_line == expack, req, "ack seen on bus", !sda_line, expack);
      tick(Q);
      scl_m = 1'b0; tick(Q);
      chk(sda_pull_o == 1'b0, "R3", "release after ack pulse", sda_pull_o, 0);
   endtask

   task automatic xfer(logic [6:0] a, bit rw, bit expack, string req);
      if (expack) exp_q.push_back(rw);
      bus_start;
      send_byte({a, rw}, expack, req);
      bus_stop;
   endtask

   task automatic pulse_reacq;
      reacq = 1'b1; tick(1);
      reacq = 1'b0; tick(1);
   endtask

   // scoreboard monitor: every strobe must match a queued expectation (R2, R4)
   always @(negedge clk) begin
      if (rst_n && addr_match_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected match strobe", 1, 0);
         end else begin
            bit e;
            e = exp_q.pop_front();
            chk(rd_nwr_o == e, "R2", "direction flag", rd_nwr_o, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R9", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [6:0] a;
      logic [1:0] lv [4];
      lv[0] = L; lv[1] = H; lv[2] = F; lv[3] = X;
      tick(5);
      chk(sda_pull_o == 0, "R3", "reset pull", sda_pull_o, 0);
      chk(addr_match_o == 0, "R2", "reset strobe", addr_match_o, 0);
      chk(rd_nwr_o == 0, "R2", "reset direction", rd_nwr_o, 0);
      rst_n = 1'b1;
      tick(3);

      // R8: first START after reset captures straps; later changes ignored
      two_pin = 1'b1; strap_hi = H; strap_lo = H;
      tick(2);
      xfer(7'b1001110, 1'b0, 1'b1, "R8");
      strap_hi = L; strap_lo = L;
      tick(2);
      xfer(7'b1001000, 1'b0, 1'b0, "R8");
      xfer(7'b1001110, 1'b1, 1'b1, "R8");
      pulse_reacq;
      xfer(7'b1001000, 1'b1, 1'b1, "R8");
      xfer(7'b1001110, 1'b0, 1'b0, "R8");

      // R5/R7: every two-pin combination including invalid codes
      two_pin = 1'b1;
      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 4; j++) begin
            strap_hi = lv[i]; strap_lo = lv[j];
            pulse_reacq;
            a = exp_addr(1'b1, lv[i], lv[j]);
            xfer(a, j[0], 1'b1, (a[2:0] == 3'd0) ? "R7" : "R5");
            xfer(a ^ 7'h01, 1'b0, 1'b0, "R5");
         end
      end

      // R6/R7: one-pin mode, upper pin set to disturbing values
      two_pin = 1'b0;
      for (int j = 0; j < 4; j++) begin
         strap_lo = lv[j]; strap_hi = lv[3 - j];
         pulse_reacq;
         a = exp_addr(1'b0, lv[3 - j], lv[j]);
         xfer(a, 1'b1, 1'b1, (j == 3) ? "R7" : "R6");
         xfer(a ^ 7'h04, 1'b1, 1'b0, "R6");
      end

      // R1: repeated START partway through an address byte
      strap_lo = F; pulse_reacq;      // address 1001001
      exp_q.push_back(1'b1);
      bus_start;
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      bus_start;
      send_byte({7'b1001001, 1'b1}, 1'b1, "R1");
      bus_stop;

      // R1: STOP partway through the address, then bits without START ignored
      bus_start;
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
      bus_stop;
      scl_m = 1'b0; tick(Q);
      send_byte({7'b1001001, 1'b0}, 1'b0, "R1");
      bus_stop;

      // R4: after a mismatch a matching byte without START is ignored
      bus_start;
      send_byte({7'b1001011, 1'b0}, 1'b0, "R4");
      send_byte({7'b1001001, 1'b0}, 1'b0, "R4");
      bus_stop;

      tick(10);
      chk(exp_q.size() == 0, "R2", "strobes still owed", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule